// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects 64 level-style interrupt request lines and turns them into two processor request outputs: a normal request and a fast request. For every source it keeps a pending bit, an enable bit, a type bit that routes the source to the fast output, and a 4-bit priority. A rising edge on a source line sets its pending bit. A falling edge clears it. Software can also overwrite the pending bits directly through the force registers.

Software reaches all state through a 32-bit register bus that uses word addresses. Normal requests pass a programmable 5-bit priority threshold. Fast requests pass regardless of priority. Two vector/status registers report the winning source and acknowledge it by read: reading one returns the source number and clears that source's pending bit in the same access. Read data is registered and appears one clock after the read strobe. Both request outputs are registered and follow the state with one clock of delay.

Top module: `prio_intc`

## Requirements
- R1: After reset, the pending, enable, type, control and priority state read as zero, the mask register (word 1) reads 0x1F, and both request outputs are low.
- R2: A 0-to-1 transition on `src_in[i]` sets pending bit i. A 1-to-0 transition clears it. Raw pending reads at word 18 (sources 63..32) and word 19 (sources 31..0).
- R3: A write to word 2 sets the enable bit numbered by write data bits [5:0], and a write to word 3 clears it. The higher data bits are ignored, and both words read as zero. Words 4 (sources 63..32) and 5 (sources 31..0) read and write the enable register directly.
- R4: Words 6 and 7 hold the type register, high and low halves, where 1 means fast. Words 22/23 read pending AND enable AND NOT type, and words 24/25 read pending AND enable AND type, each as high/low halves.
- R5: Priority nibble for source i lies at bits 4*(i mod 8) of priority word i/8. Word address 15-w accesses priority word w, so address 8 covers sources 56..63.
- R6: `irq_fast_o` is high one clock after some source is pending, enabled and fast, and low one clock after no such source exists.
- R7: With mask 0x1F, `irq_norm_o` is high one clock after any enabled, pending, normal-type source exists.
- R8: With mask m below 0x1F, `irq_norm_o` is high only if such a source has priority strictly greater than m, so masks 15 to 30 block all normal requests.
- R9: Reading word 16 returns {source[15:0], priority[15:0]} of the qualifying normal source with the highest priority, taking the higher source number on a tie. The read clears that pending bit. It returns 0xFFFFFFFF when no source qualifies.
- R10: Reading word 17 returns the lowest-numbered enabled, pending, fast source and clears its pending bit, regardless of priority. It returns 0xFFFFFFFF when none qualifies.
- R11: Writes to word 20 (high) and word 21 (low) replace that half of the pending register, and both words read as zero.
- R12: Writes to words 16-19 and 22-25 change no state. When a source edge and a vector-read clear hit the same source in one cycle, the edge wins.
- R13: The control register (word 0) keeps only bits 24 and 22..18 of a write. The mask register keeps 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Interrupt source lines |
| bus_addr | input | 6 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; vector words acknowledge on it |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| irq_norm_o | output | 1 | Normal interrupt request, registered |
| irq_fast_o | output | 1 | Fast interrupt request, registered |

## Verification
The hardest case to reach is an acknowledging vector read that lands in the same cycle as a new rising edge on the source it selects. The bench first preloads that source's pending bit through a force register. It then raises the source line and asserts the vector read on the same falling clock edge, so both events meet at one rising edge. Priority ties and the reverse priority-word mapping only show up in the order that repeated vector reads drain a fully forced pending set. The bench therefore gives the sources a repeating priority pattern and predicts the whole drain order arithmetically.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned ADR_W = 6;

  localparam logic [ADR_W-1:0] A_CTRL     = 6'd0;
  localparam logic [ADR_W-1:0] A_MASK     = 6'd1;
  localparam logic [ADR_W-1:0] A_ENNUM    = 6'd2;
  localparam logic [ADR_W-1:0] A_DISNUM   = 6'd3;
  localparam logic [ADR_W-1:0] A_ENHI     = 6'd4;
  localparam logic [ADR_W-1:0] A_ENLO     = 6'd5;
  localparam logic [ADR_W-1:0] A_TYHI     = 6'd6;
  localparam logic [ADR_W-1:0] A_TYLO     = 6'd7;
  localparam logic [ADR_W-1:0] A_PRIO_LO  = 6'd8;
  localparam logic [ADR_W-1:0] A_PRIO_HI  = 6'd15;
  localparam logic [ADR_W-1:0] A_NVEC     = 6'd16;
  localparam logic [ADR_W-1:0] A_FVEC     = 6'd17;
  localparam logic [ADR_W-1:0] A_RAWHI    = 6'd18;
  localparam logic [ADR_W-1:0] A_RAWLO    = 6'd19;
  localparam logic [ADR_W-1:0] A_FRCHI    = 6'd20;
  localparam logic [ADR_W-1:0] A_FRCLO    = 6'd21;
  localparam logic [ADR_W-1:0] A_NPHI     = 6'd22;
  localparam logic [ADR_W-1:0] A_NPLO     = 6'd23;
  localparam logic [ADR_W-1:0] A_FPHI     = 6'd24;
  localparam logic [ADR_W-1:0] A_FPLO     = 6'd25;

  localparam logic [BUS_W-1:0] CTRL_KEEP  = 32'h017C_0000;
  localparam logic [BUS_W-1:0] VEC_EMPTY  = '1;
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned W    = 32,
  localparam int unsigned HALF = NSRC / 2,
  localparam int unsigned IW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic            frc_hi,
  input  logic            frc_lo,
  input  logic [W-1:0]    frc_data,
  input  logic            ack,
  input  logic [IW-1:0]   ack_idx,
  output logic [NSRC-1:0] pending
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] rise, fall, nxt;

  assign rise = src_in & ~src_q;
  assign fall = ~src_in & src_q;

  // force, then acknowledge clear, then line edges (edges have the last word)
  always_comb begin
    nxt = pending;
    if (frc_lo) nxt[HALF-1:0]    = frc_data[HALF-1:0];
    if (frc_hi) nxt[NSRC-1:HALF] = frc_data[HALF-1:0];
    if (ack)    nxt[ack_idx]     = 1'b0;
    nxt = (nxt | rise) & ~fall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '0;
      pending <= '0;
    end else begin
      src_q   <= src_in;
      pending <= nxt;
    end
  end
endmodule

// File: rtl/intc_prio_file.sv
module intc_prio_file #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned PW   = 4,
  parameter int unsigned W    = 32,
  localparam int unsigned PER   = W / PW,
  localparam int unsigned NWORD = NSRC / PER,
  localparam int unsigned XW    = $clog2(NWORD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [XW-1:0]    widx,
  input  logic [W-1:0]     wdata,
  input  logic [XW-1:0]    ridx,
  output logic [W-1:0]     rword,
  output logic [NSRC*PW-1:0] prio_flat
);
  logic [W-1:0] words [NWORD];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NWORD; w++) words[w] <= '0;
    end else if (we) begin
      words[widx] <= wdata;
    end
  end

  assign rword = words[ridx];

  for (genvar g = 0; g < NWORD; g++) begin : g_flat
    assign prio_flat[g*W +: W] = words[g];
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned PW   = 4,
  localparam int unsigned IW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]    norm_cand,
  input  logic [NSRC-1:0]    fast_cand,
  input  logic [NSRC*PW-1:0] prio_flat,
  output logic               norm_hit,
  output logic [IW-1:0]      norm_idx,
  output logic [PW-1:0]      norm_prio,
  output logic               fast_hit,
  output logic [IW-1:0]      fast_idx
);
  // ascending scan with >= : later (higher-numbered) sources win ties
  always_comb begin
    norm_hit  = 1'b0;
    norm_idx  = '0;
    norm_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (norm_cand[i] && (!norm_hit || prio_flat[i*PW +: PW] >= norm_prio)) begin
        norm_hit  = 1'b1;
        norm_idx  = IW'(i);
        norm_prio = prio_flat[i*PW +: PW];
      end
    end
  end

  // descending scan: the last assignment is the lowest-numbered source
  always_comb begin
    fast_hit = 1'b0;
    fast_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (fast_cand[i]) begin
        fast_hit = 1'b1;
        fast_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned PW   = 4,
  localparam int unsigned W      = intc_pkg::BUS_W,
  localparam int unsigned AW     = intc_pkg::ADR_W,
  localparam int unsigned HALF   = NSRC / 2,
  localparam int unsigned IW     = $clog2(NSRC),
  localparam int unsigned MASK_W = PW + 1,
  localparam int unsigned NWORD  = NSRC / (W / PW),
  localparam int unsigned XW     = $clog2(NWORD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  output logic            irq_norm_o,
  output logic            irq_fast_o
);
  import intc_pkg::*;

  logic [NSRC-1:0]   pending, enable_q, ftype_q;
  logic [MASK_W-1:0] mask_q;
  logic [W-1:0]      ctrl_q;
  logic [NSRC-1:0]   nset, fset;
  logic [NSRC*PW-1:0] prio_flat;
  logic [W-1:0]      prio_word, rmux;
  logic              in_prio;
  logic [XW-1:0]     prio_sel;
  logic              norm_hit, fast_hit;
  logic [IW-1:0]     norm_idx, fast_idx;
  logic [PW-1:0]     norm_prio;
  logic              ack_n, ack_f;

  assign nset     = pending & enable_q & ~ftype_q;
  assign fset     = pending & enable_q & ftype_q;
  assign in_prio  = (bus_addr >= A_PRIO_LO) && (bus_addr <= A_PRIO_HI);
  assign prio_sel = XW'(A_PRIO_HI - bus_addr);
  assign ack_n    = bus_re && (bus_addr == A_NVEC) && norm_hit;
  assign ack_f    = bus_re && (bus_addr == A_FVEC) && fast_hit;

  intc_pending #(.NSRC(NSRC), .W(W)) u_pend (
    .clk(clk), .rst(rst), .src_in(src_in),
    .frc_hi(bus_we && bus_addr == A_FRCHI),
    .frc_lo(bus_we && bus_addr == A_FRCLO),
    .frc_data(bus_wdata),
    .ack(ack_n || ack_f),
    .ack_idx(ack_f ? fast_idx : norm_idx),
    .pending(pending)
  );

  intc_prio_file #(.NSRC(NSRC), .PW(PW), .W(W)) u_prio (
    .clk(clk), .rst(rst),
    .we(bus_we && in_prio), .widx(prio_sel), .wdata(bus_wdata),
    .ridx(prio_sel), .rword(prio_word), .prio_flat(prio_flat)
  );

  intc_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
    .norm_cand(nset), .fast_cand(fset), .prio_flat(prio_flat),
    .norm_hit(norm_hit), .norm_idx(norm_idx), .norm_prio(norm_prio),
    .fast_hit(fast_hit), .fast_idx(fast_idx)
  );

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      ftype_q  <= '0;
      mask_q   <= '1;
      ctrl_q   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_CTRL:   ctrl_q <= bus_wdata & CTRL_KEEP;
        A_MASK:   mask_q <= bus_wdata[MASK_W-1:0];
        A_ENNUM:  enable_q[bus_wdata[IW-1:0]] <= 1'b1;
        A_DISNUM: enable_q[bus_wdata[IW-1:0]] <= 1'b0;
        A_ENHI:   enable_q[NSRC-1:HALF] <= bus_wdata[HALF-1:0];
        A_ENLO:   enable_q[HALF-1:0]    <= bus_wdata[HALF-1:0];
        A_TYHI:   ftype_q[NSRC-1:HALF]  <= bus_wdata[HALF-1:0];
        A_TYLO:   ftype_q[HALF-1:0]     <= bus_wdata[HALF-1:0];
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rmux = '0;
    if (in_prio) begin
      rmux = prio_word;
    end else begin
      case (bus_addr)
        A_CTRL:  rmux = ctrl_q;
        A_MASK:  rmux = W'(mask_q);
        A_ENHI:  rmux = W'(enable_q[NSRC-1:HALF]);
        A_ENLO:  rmux = W'(enable_q[HALF-1:0]);
        A_TYHI:  rmux = W'(ftype_q[NSRC-1:HALF]);
        A_TYLO:  rmux = W'(ftype_q[HALF-1:0]);
        A_NVEC:  rmux = norm_hit ? {16'(norm_idx), 16'(norm_prio)} : VEC_EMPTY;
        A_FVEC:  rmux = fast_hit ? W'(fast_idx) : VEC_EMPTY;
        A_RAWHI: rmux = W'(pending[NSRC-1:HALF]);
        A_RAWLO: rmux = W'(pending[HALF-1:0]);
        A_NPHI:  rmux = W'(nset[NSRC-1:HALF]);
        A_NPLO:  rmux = W'(nset[HALF-1:0]);
        A_FPHI:  rmux = W'(fset[NSRC-1:HALF]);
        A_FPLO:  rmux = W'(fset[HALF-1:0]);
        default: rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      irq_norm_o <= 1'b0;
      irq_fast_o <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= rmux;
      irq_fast_o <= |fset;
      irq_norm_o <= (&mask_q) ? (|nset)
                              : (norm_hit && ({1'b0, norm_prio} > mask_q));
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int unsigned NSRC = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_in,
  input logic [NSRC-1:0] pending,
  input logic [NSRC-1:0] enable_q,
  input logic [NSRC-1:0] ftype_q,
  input logic [4:0]      mask_q,
  input logic [5:0]      bus_addr,
  input logic            bus_we,
  input logic            irq_norm_o,
  input logic            irq_fast_o
);
  logic [NSRC-1:0] in_q;
  logic            rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) in_q <= '0;
    else     in_q <= src_in;
    if (rst_q) begin
      a_r1_reset_state: assert (pending == '0 && enable_q == '0 && ftype_q == '0 &&
                                mask_q == 5'h1F && !irq_norm_o && !irq_fast_o);
    end
  end

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pending & $past(src_in & ~in_q)) == $past(src_in & ~in_q)));

  a_r2_fall_clears: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pending & $past(~src_in & in_q)) == '0));

  a_r6_fast_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_fast_o == $past(|(pending & enable_q & ftype_q))));

  a_r7_open_mask: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask_q) == 5'h1F) |->
      (irq_norm_o == $past(|(pending & enable_q & ~ftype_q))));

  a_r8_high_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask_q) >= 5'd15 && $past(mask_q) != 5'h1F) |-> !irq_norm_o);

  a_r12_ro_writes: assert property (@(posedge clk) disable iff (rst)
    (bus_we && ((bus_addr >= 6'd16 && bus_addr <= 6'd19) ||
                (bus_addr >= 6'd22 && bus_addr <= 6'd25)))
      |=> ($stable(enable_q) && $stable(ftype_q) && $stable(mask_q)));
endmodule

bind prio_intc intc_checker #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .src_in(src_in), .pending(pending),
  .enable_q(enable_q), .ftype_q(ftype_q), .mask_q(mask_q),
  .bus_addr(bus_addr), .bus_we(bus_we),
  .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n, irq_f;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  prio_intc dut (
    .clk(clk), .rst(rst), .src_in(src), .bus_addr(addr), .bus_we(we),
    .bus_re(re), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_norm_o(irq_n), .irq_fast_o(irq_f)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [3:0] pf(input int i);
    return 4'((i * 5 + 3) % 16);
  endfunction

  function automatic logic [31:0] pword(input int w);
    logic [31:0] v = '0;
    for (int j = 0; j < 8; j++) v[4*j +: 4] = pf(8*w + j);
    return v;
  endfunction

  function automatic logic [31:0] best_norm(input logic [63:0] s);
    int bi = -1; int bp = -1;
    for (int i = 0; i < 64; i++)
      if (s[i] && int'(pf(i)) >= bp) begin bi = i; bp = int'(pf(i)); end
    return (bi < 0) ? 32'hFFFF_FFFF : {16'(bi), 16'(bp)};
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] m, pend, en, ty;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_norm", 32'(irq_n), 0);
    chk("R1 irq_fast", 32'(irq_f), 0);
    rd(6'd1, d);  chk("R1 mask", d, 32'h1F);
    rd(6'd5, d);  chk("R1 enable", d, 0);
    rd(6'd7, d);  chk("R1 type", d, 0);
    rd(6'd19, d); chk("R1 pending", d, 0);
    rd(6'd8, d);  chk("R1 prio", d, 0);
    rd(6'd0, d);  chk("R1 ctrl", d, 0);

    // R13 control and mask widths
    wr(6'd0, 32'hFFFF_FFFF); rd(6'd0, d); chk("R13 ctrl bits", d, 32'h017C_0000);
    wr(6'd1, 32'hFFFF_FFEA); rd(6'd1, d); chk("R13 mask bits", d, 32'h0A);
    wr(6'd1, 32'h1F);

    // R3 enable by number / disable by number
    for (int i = 0; i < 64; i++) wr(6'd2, 32'(i) | 32'hFFFF_FFC0);
    for (int i = 0; i < 64; i += 2) wr(6'd3, 32'(i) | 32'h0000_7700);
    rd(6'd4, d); chk("R3 en hi", d, 32'hAAAA_AAAA);
    rd(6'd5, d); chk("R3 en lo", d, 32'hAAAA_AAAA);
    rd(6'd2, d); chk("R3 ennum reads 0", d, 0);
    rd(6'd3, d); chk("R3 disnum reads 0", d, 0);
    wr(6'd4, 32'h1234_5678); wr(6'd5, 32'h9ABC_DEF0);
    rd(6'd4, d); chk("R3 en hi rw", d, 32'h1234_5678);
    rd(6'd5, d); chk("R3 en lo rw", d, 32'h9ABC_DEF0);

    // R4 type register
    wr(6'd6, 32'hCAFE_0001); wr(6'd7, 32'h8000_BEEF);
    rd(6'd6, d); chk("R4 type hi", d, 32'hCAFE_0001);
    rd(6'd7, d); chk("R4 type lo", d, 32'h8000_BEEF);

    // R5 priority words, address 15-w holds word w
    for (int w = 0; w < 8; w++) wr(6'(15 - w), pword(w));
    for (int w = 0; w < 8; w++) begin
      rd(6'(15 - w), d); chk("R5 prio word", d, pword(w));
    end

    // R2 edge sweep over every source
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); src[i] = 1'b1;
      settle();
      rd(i >= 32 ? 6'd18 : 6'd19, d);
      chk("R2 rise", d, 32'(1) << (i % 32));
      @(negedge clk); src[i] = 1'b0;
      settle();
      rd(i >= 32 ? 6'd18 : 6'd19, d);
      chk("R2 fall", d, 0);
    end

    // R11 force, R4 pending views, R6 fast output
    en = 64'hF0F0_F0F0_0F0F_0F0F; ty = 64'hFF00_FF00_00FF_00FF;
    pend = 64'hFFFF_0000_FFFF_FFFF;
    wr(6'd4, en[63:32]); wr(6'd5, en[31:0]);
    wr(6'd6, ty[63:32]); wr(6'd7, ty[31:0]);
    wr(6'd20, pend[63:32]); wr(6'd21, pend[31:0]);
    rd(6'd18, d); chk("R11 force hi", d, pend[63:32]);
    rd(6'd19, d); chk("R11 force lo", d, pend[31:0]);
    rd(6'd20, d); chk("R11 force reads 0", d, 0);
    rd(6'd21, d); chk("R11 force reads 0", d, 0);
    m = pend & en & ~ty;
    rd(6'd22, d); chk("R4 norm pend hi", d, m[63:32]);
    rd(6'd23, d); chk("R4 norm pend lo", d, m[31:0]);
    m = pend & en & ty;
    rd(6'd24, d); chk("R4 fast pend hi", d, m[63:32]);
    rd(6'd25, d); chk("R4 fast pend lo", d, m[31:0]);
    settle(); chk("R6 fast high", 32'(irq_f), 1);
    wr(6'd6, 0); wr(6'd7, 0);
    settle(); chk("R6 fast low", 32'(irq_f), 0);

    // R7 / R8 mask sweep with one pending normal source
    wr(6'd4, '1); wr(6'd5, '1);
    foreach (m[k]) m[k] = 1'b0;
    for (int t = 0; t < 3; t++) begin
      int s;
      s = (t == 0) ? 0 : (t == 1) ? 37 : 63;
      m = 64'(1) << s;
      wr(6'd20, m[63:32]); wr(6'd21, m[31:0]);
      for (int k = 0; k < 32; k++) begin
        wr(6'd1, 32'(k));
        settle();
        if (k == 31) chk("R7 open mask", 32'(irq_n), 1);
        else chk("R8 threshold", 32'(irq_n), 32'(int'(pf(s)) > k));
      end
    end
    wr(6'd20, 0); wr(6'd21, 0);
    settle(); chk("R7 none pending", 32'(irq_n), 0);

    // R9 drain all sources through the normal vector
    wr(6'd20, '1); wr(6'd21, '1);
    m = '1;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] e;
      e = best_norm(m);
      rd(6'd16, d); chk("R9 vector", d, e);
      m[e[31:16]] = 1'b0;
    end
    rd(6'd16, d); chk("R9 empty", d, 32'hFFFF_FFFF);
    rd(6'd19, d); chk("R9 cleared", d, 0);

    // R10 fast vector, lowest number first, normal vector skips fast sources
    ty = 64'h0000_FFFF_FFFF_0000;
    wr(6'd6, ty[63:32]); wr(6'd7, ty[31:0]);
    wr(6'd20, '1); wr(6'd21, '1);
    for (int i = 16; i < 48; i++) begin
      rd(6'd17, d); chk("R10 fast vector", d, 32'(i));
    end
    rd(6'd17, d); chk("R10 empty", d, 32'hFFFF_FFFF);
    rd(6'd16, d); chk("R9 skips fast", d, best_norm(~ty));

    // R12 edge wins over acknowledge clear on same source
    wr(6'd6, 0); wr(6'd7, 0);
    wr(6'd20, 0); wr(6'd21, 32'h20);
    @(negedge clk); src[5] = 1'b1; addr = 6'd16; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
    chk("R12 vector on race", d, {16'd5, 16'(pf(5))});
    rd(6'd19, d); chk("R12 edge wins", d, 32'h20);
    @(negedge clk); src[5] = 1'b0;
    settle();

    // R12 read-only words ignore writes
    wr(6'd21, 32'h0000_0300);
    wr(6'd19, '1); wr(6'd18, '1); wr(6'd23, '1); wr(6'd16, '1); wr(6'd25, 0);
    rd(6'd19, d); chk("R12 raw lo unchanged", d, 32'h0000_0300);
    rd(6'd18, d); chk("R12 raw hi unchanged", d, 0);
    rd(6'd5, d);  chk("R12 enable unchanged", d, 32'hFFFF_FFFF);
    rd(6'd1, d);  chk("R12 mask unchanged", d, 32'h1F);

    summary();
  end
endmodule